// File: doc/BRIEF.md
# Peripheral Port Strobe Output Controller

This block models the B-side handshake output line of a parallel peripheral adapter. A processor reaches it over a simple bus with a chip select, a register select, a read/write line and a free-running E bus clock. Two registers can be written: a port data register, whose contents appear on an output port, and a control register, whose mode field decides how the single strobe output behaves.

In the automatic mode, a write to the data register sends the strobe low at the next rising edge of E. The line stays low until the first E cycle in which the device is not selected, and returns high at the rising edge of E that follows that cycle. The pulse width therefore depends on bus traffic, not on a fixed count. A downstream device latches on the rising edge of the strobe, so the data register must not change between the write that starts a pulse and the edge that ends it. Two manual modes hold the strobe at a fixed level taken from one control bit. All other mode values keep it high.

All bus inputs are sampled on the system clock. The edges of E are found with one register stage.

Top module: `port_strobe_ctrl`

## Requirements
- R1: After reset the control register and the data register read as zero, the strobe output is high and no pulse is pending. A reset in the middle of a pulse returns the strobe high at once.
- R2: A write takes effect at the falling edge of E only when chip select is high and the read/write line is low (0 = write). Register select 0 picks the data register and 1 picks the control register. Cycles that are deselected, and read cycles, change neither register.
- R3: When control bits 5..3 are 101 (automatic mode), a data register write drives the strobe low at the first rising edge of E after that write.
- R4: In automatic mode a low strobe returns high at the rising edge of E that follows an E cycle in which chip select was low when E fell.
- R5: In automatic mode, selected read cycles do not end a pulse. The strobe stays low through them.
- R6: A second data write while the strobe is low keeps it low and restarts the wait for a deselected cycle.
- R7: Control bits 5..3 equal to 110 hold the strobe low, and 111 hold it high (the level is control bit 3). The new level applies from the falling edge of E that writes the control register. The value 0xF7 decodes as 110 and holds the strobe low.
- R8: With any other value in control bits 5..3, the strobe is high and data writes start no pulse.
- R9: The data output does not change in the cycle in which the strobe rises.
- R10: A control register write cancels any pending or active automatic pulse and sets the pulse line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all bus inputs |
| rstN | input | 1 | Synchronous active-low reset |
| eBus | input | 1 | E bus clock |
| chipSel | input | 1 | Device select, active high |
| regSel | input | 1 | 0 selects the data register, 1 selects the control register |
| rwN | input | 1 | 1 for a read cycle, 0 for a write cycle |
| wrData | input | DATA_W | Write data from the processor |
| portData | output | DATA_W | Current data register contents |
| strobeOut | output | 1 | Handshake strobe output line |

## Verification
Two functions can land on the same E edge. A rising edge of E can release or start a pulse while the same bus cycle writes the control register. A data write can also arrive while the strobe is already low, which collides with the pending release.

The bench provokes the first case by writing the data register and then writing the control register in the very next bus cycle. It then checks that the strobe is low while E is high and high again after E falls. For the second case, it checks that the release waits for a deselected cycle that comes after the second write.

// File: rtl/port_strobe_pkg.sv
package port_strobe_pkg;
  localparam int MODE_LSB = 3;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_AUTO = 3'b101;
  localparam logic [MODE_W-2:0] MODE_MANUAL_HI = 2'b11;

  typedef struct packed {
    logic eRise;
    logic eFall;
    logic wrData;
    logic wrCtrl;
    logic deselFall;
  } busStrobes_t;
endpackage

// File: rtl/port_strobe_bus.sv
module port_strobe_bus
  import port_strobe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        eBus,
  input  logic        chipSel,
  input  logic        regSel,
  input  logic        rwN,
  output busStrobes_t stb
);
  logic ePrev;

  always_ff @(posedge clk) begin
    if (!rstN) ePrev <= 1'b0;
    else       ePrev <= eBus;
  end

  always_comb begin
    stb.eRise     = eBus & ~ePrev;
    stb.eFall     = ~eBus & ePrev;
    stb.wrData    = stb.eFall & chipSel & ~rwN & ~regSel;
    stb.wrCtrl    = stb.eFall & chipSel & ~rwN & regSel;
    stb.deselFall = stb.eFall & ~chipSel;
  end

  // R2: at most one register is written per cycle, and never while deselected
  p_one_target_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrData, stb.wrCtrl, stb.deselFall}));

  // R2: writes only come from the falling phase of E
  p_write_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrData | stb.wrCtrl) |-> (ePrev && !eBus));
endmodule

// File: rtl/port_strobe_core.sv
module port_strobe_core
  import port_strobe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] portData,
  output logic              strobeOut
);
  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] dataReg;
  logic [MODE_W-1:0] modeField;
  logic              isAuto;
  logic              pulseLine;
  logic              pendLow;
  logic              relArm;

  assign modeField = ctrlReg[MODE_LSB +: MODE_W];
  assign isAuto    = (modeField == MODE_AUTO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      dataReg   <= '0;
      pulseLine <= 1'b1;
      pendLow   <= 1'b0;
      relArm    <= 1'b0;
    end else if (stb.wrCtrl) begin
      ctrlReg   <= wrData;
      pulseLine <= 1'b1;
      pendLow   <= 1'b0;
      relArm    <= 1'b0;
    end else begin
      if (stb.wrData) begin
        dataReg <= wrData;
        if (isAuto) begin
          pendLow <= 1'b1;
          relArm  <= 1'b0;
        end
      end
      if (stb.eRise && isAuto) begin
        if (pendLow) begin
          pulseLine <= 1'b0;
          pendLow   <= 1'b0;
        end else if (relArm) begin
          pulseLine <= 1'b1;
          relArm    <= 1'b0;
        end
      end
      if (stb.deselFall && isAuto && !pulseLine && !pendLow) relArm <= 1'b1;
    end
  end

  always_comb begin
    if (isAuto)                                          strobeOut = pulseLine;
    else if (modeField[MODE_W-1:1] == MODE_MANUAL_HI)    strobeOut = ctrlReg[MODE_LSB];
    else                                                 strobeOut = 1'b1;
  end

  assign portData = dataReg;

  // R1: reset leaves the line high and the registers clear
  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (strobeOut && ctrlReg == '0 && portData == '0));

  // R3: the pulse line only falls at a rising edge of E
  p_fall_on_erise_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseLine) |-> $past(stb.eRise));

  // R9: data presented downstream is stable across the strobe rising edge
  p_data_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeOut) |-> $stable(portData));

  // R10: a control write always leaves the pulse line released
  p_ctrl_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCtrl |=> pulseLine);
endmodule

// File: rtl/port_strobe_ctrl.sv
module port_strobe_ctrl
  import port_strobe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eBus,
  input  logic              chipSel,
  input  logic              regSel,
  input  logic              rwN,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] portData,
  output logic              strobeOut
);
  busStrobes_t stb;

  port_strobe_bus bus_i (
    .clk     (clk),
    .rstN    (rstN),
    .eBus    (eBus),
    .chipSel (chipSel),
    .regSel  (regSel),
    .rwN     (rwN),
    .stb     (stb)
  );

  port_strobe_core #(.DATA_W(DATA_W)) core_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .portData  (portData),
    .strobeOut (strobeOut)
  );
endmodule

// File: tb/port_strobe_ctrl_tb.sv
module port_strobe_ctrl_tb_top;
  localparam int DATA_W = 8;
  localparam int NVEC = 22;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eBus = 1'b0;
  logic chipSel = 1'b0;
  logic regSel = 1'b0;
  logic rwN = 1'b1;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] portData;
  logic strobeOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  port_strobe_ctrl #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .eBus(eBus), .chipSel(chipSel), .regSel(regSel),
    .rwN(rwN), .wrData(wrData), .portData(portData), .strobeOut(strobeOut)
  );

  // vector fields: sel, rs, rwN, data, strobe while E high, strobe after E low, data out
  typedef struct packed {
    logic       sel;
    logic       rs;
    logic       rw;
    logic [7:0] wd;
    logic       expHi;
    logic       expEnd;
    logic [7:0] expData;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 1'b0, 8'h28, 1'b1, 1'b1, 8'h00}, // enter automatic mode
    '{1'b1, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b1, 8'hA5}, // R2 data write
    '{1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'hA5}, // R3 low at next rise
    '{1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'hA5}, // deselected cycle
    '{1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 8'hA5}, // R4 released
    '{1'b1, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b1, 8'h3C}, // new pulse
    '{1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h3C}, // R5 selected read keeps low
    '{1'b1, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0, 8'h5A}, // R6 second write
    '{1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h5A}, // R6 still low
    '{1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h5A}, // deselected
    '{1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 8'h5A}, // R4 released
    '{1'b0, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b1, 8'h5A}, // R2 deselected write ignored
    '{1'b1, 1'b1, 1'b0, 8'hF7, 1'b1, 1'b0, 8'h5A}, // R7 0xF7 holds low
    '{1'b1, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0, 8'h11}, // R7 data write, steady low
    '{1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h11}, // R7 deselect no effect
    '{1'b1, 1'b1, 1'b0, 8'h38, 1'b0, 1'b1, 8'h11}, // R7 mode 111 high
    '{1'b1, 1'b1, 1'b0, 8'h20, 1'b1, 1'b1, 8'h11}, // R8 mode 100
    '{1'b1, 1'b0, 1'b0, 8'h77, 1'b1, 1'b1, 8'h77}, // R8 no pulse
    '{1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 8'h77}, // R8 still high
    '{1'b1, 1'b1, 1'b0, 8'h28, 1'b1, 1'b1, 8'h77}, // automatic again
    '{1'b1, 1'b0, 1'b0, 8'h99, 1'b1, 1'b1, 8'h99}, // start pulse
    '{1'b1, 1'b1, 1'b0, 8'h28, 1'b0, 1'b1, 8'h99}  // R10 ctrl write cancels
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busCycle(input vec_t v, input string tag);
    @(negedge clk);
    chipSel = v.sel; regSel = v.rs; rwN = v.rw; wrData = v.wd; eBus = 1'b1;
    repeat (3) @(negedge clk);
    check({tag, " strobe E high"}, {7'd0, strobeOut}, {7'd0, v.expHi});
    eBus = 1'b0;
    repeat (2) @(negedge clk);
    check({tag, " strobe E low"}, {7'd0, strobeOut}, {7'd0, v.expEnd});
    check({tag, " data R2"}, portData, v.expData);
    chipSel = 1'b0; rwN = 1'b1; wrData = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset strobe", {7'd0, strobeOut}, 8'd1);
    check("R1 reset data", portData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NVEC; i++) busCycle(VECS[i], $sformatf("vec%0d", i));
    // R1: reset in the middle of an active pulse
    busCycle('{1'b1, 1'b0, 1'b0, 8'hC3, 1'b1, 1'b1, 8'hC3}, "R1 pre");
    busCycle('{1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'hC3}, "R3 pre");
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 mid-pulse strobe", {7'd0, strobeOut}, 8'd1);
    check("R1 mid-pulse data", portData, 8'h00);
    rstN = 1'b1;
    // R8: after reset mode is 000, data write gives no pulse
    busCycle('{1'b1, 1'b0, 1'b0, 8'h42, 1'b1, 1'b1, 8'h42}, "R8 post");
    busCycle('{1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 8'h42}, "R8 post2");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule